// File: doc/BRIEF.md
# Load-Dependent Switching Frequency Scheduler

This block sets the switching period of a PWM power stage from the voltage-loop error value, which stands for the load. The input is an unsigned error code in millivolts. The output is a period count in system clock cycles, plus a flag that marks the lowest-power operating region. The error value maps onto three regions. At heavy load the stage runs at its nominal rate. Across a middle band the rate falls in a straight line with the error value. At the lightest loads the rate is pinned at a floor and the idle flag is raised.

The interpolation works on frequency, not on period. A shared iterative divider turns the interpolated frequency into a period count. It runs all the time in the background and keeps a pending result up to date. The gate generator pulses a cycle-start strobe at the start of each switching cycle. Only on that strobe are the pending period and flag moved to the outputs, so a cycle already running is never resized.

Top module: `fsw_sched`

## Requirements
- R1: While rst_n is low, on each clock edge period_o becomes 238 (the nominal 42 kHz period at 10 MHz, truncated) and deep_idle_o becomes 0.
- R2: With err_mv_i at or above 2800, after a strobe period_o is 238 and deep_idle_o is 0.
- R3: With err_mv_i strictly between 800 and 2800, after a strobe period_o equals floor(10^7 * 2000 / (550 * 2000 + (err_mv_i - 800) * 41450)) and deep_idle_o is 0.
- R4: With err_mv_i at or below 800, after a strobe period_o is 18181 (the 550 Hz floor) and deep_idle_o is 1. Whenever deep_idle_o is 1, period_o is 18181.
- R5: The idle flag depends only on the error value. An error of 801 gives deep_idle_o 0 and a period just below the floor (17521).
- R6: period_o and deep_idle_o change only on the clock edge where cycle_start_i is 1. A change of err_mv_i with no strobe leaves both outputs as they are.
- R7: An error value held stable for at least 80 clock cycles before a strobe is the value that the strobe loads.
- R8: period_o always lies between 238 and 18181 inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (10 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| err_mv_i | input | 12 | Voltage-loop error value in millivolts |
| cycle_start_i | input | 1 | One-cycle strobe at the start of each switching cycle |
| period_o | output | 20 | Switching period in system clock cycles |
| deep_idle_o | output | 1 | High while the floor frequency is in force |

## Verification
The bench goes after the knee edges: 800, 801, 2799 and 2800, plus the code extremes 0 and 4095. An off-by-one in the region compare would show up there as a wrong idle flag at 801, or as a period that is not quite nominal at 2800. A slope or divider bit error would give ramp periods away from the reciprocal formula, and random ramp values expose it. The bench also changes the error value without a strobe. A design that let outputs follow the divider directly would resize the running cycle there, and the unchanged outputs catch it.

// File: rtl/fsw_pkg.sv
// Package: default operating constants and the region type shared by the
// frequency scheduler modules. Assumes a 10 MHz system clock by default.
package fsw_pkg;
    localparam int DEF_CLK_HZ   = 10_000_000;
    localparam int DEF_F_NOM    = 42_000;
    localparam int DEF_F_MIN    = 550;
    localparam int DEF_KNEE_HI  = 2800;
    localparam int DEF_KNEE_LO  = 800;
    localparam int DEF_ERR_W    = 12;
    localparam int DEF_PER_W    = 20;

    // Operating region selected by the load indicator
    typedef enum logic [1:0] {
        REG_FULL  = 2'd0,
        REG_RAMP  = 2'd1,
        REG_FLOOR = 2'd2
    } region_e;
endpackage

// File: rtl/fsw_region_map.sv
// Region mapper: clamps the error value into the ramp band and forms the
// interpolated frequency scaled by the band width (the divisor). Assumes
// KNEE_HI > KNEE_LO and F_NOM > F_MIN. Purely combinational.
module fsw_region_map
    import fsw_pkg::*;
#(
    parameter int ERR_W   = DEF_ERR_W,
    parameter int KNEE_HI = DEF_KNEE_HI,
    parameter int KNEE_LO = DEF_KNEE_LO,
    parameter int F_NOM   = DEF_F_NOM,
    parameter int F_MIN   = DEF_F_MIN,
    parameter int DEN_W   = 27
) (
    input  logic [ERR_W-1:0] err_i,
    output logic [DEN_W-1:0] den_o,
    output region_e          region_o
);
    localparam int SPAN  = KNEE_HI - KNEE_LO;
    localparam int SLOPE = F_NOM - F_MIN;
    localparam int BASE  = F_MIN * SPAN;

    logic [ERR_W-1:0] ofs;

    // Classify the error value and clamp its offset into [0, SPAN]
    always_comb begin
        if (int'(err_i) >= KNEE_HI) begin
            ofs      = ERR_W'(SPAN);
            region_o = REG_FULL;
        end else if (int'(err_i) <= KNEE_LO) begin
            ofs      = '0;
            region_o = REG_FLOOR;
        end else begin
            ofs      = err_i - ERR_W'(KNEE_LO);
            region_o = REG_RAMP;
        end
    end

    // Scaled frequency: F_MIN*SPAN + ofs*(F_NOM-F_MIN)
    always_comb begin
        den_o = DEN_W'(BASE) + DEN_W'(ofs) * DEN_W'(SLOPE);
    end
endmodule

// File: rtl/fsw_recip_div.sv
// Reciprocal divider: restoring long division of a fixed numerator by the
// scaled frequency, one quotient bit per clock. It restarts by itself as
// soon as it finishes, so it always tracks the latest divisor. Assumes the
// divisor is never zero and the quotient fits NUM_W bits.
module fsw_recip_div
    import fsw_pkg::*;
#(
    parameter int     NUM_W = 35,
    parameter int     DEN_W = 27,
    parameter longint NUM_V = 64'd20_000_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEN_W-1:0] den_i,
    input  region_e          tag_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o,
    output region_e          tag_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [NUM_W-1:0] NUM_C = NUM_W'(NUM_V);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [NUM_W-1:0] num_sh;
    logic [DEN_W-1:0] rem;
    logic [NUM_W-1:0] quo;
    logic [DEN_W-1:0] den_q;
    region_e          tag_q;

    logic [DEN_W:0]   rem_sh;
    logic             take;
    logic [DEN_W:0]   rem_sub;

    // One division step: bring down the next numerator bit and compare
    always_comb begin
        rem_sh  = {rem, num_sh[NUM_W-1]};
        take    = (rem_sh >= {1'b0, den_q});
        rem_sub = rem_sh - {1'b0, den_q};
    end

    // Sequence the division and publish each finished quotient
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            num_sh <= '0;
            rem    <= '0;
            quo    <= '0;
            den_q  <= '0;
            tag_q  <= REG_FULL;
            done_o <= 1'b0;
            quo_o  <= '0;
            tag_o  <= REG_FULL;
        end else begin
            done_o <= 1'b0;
            if (!busy) begin
                busy   <= 1'b1;
                cnt    <= '0;
                num_sh <= NUM_C;
                rem    <= '0;
                quo    <= '0;
                den_q  <= den_i;
                tag_q  <= tag_i;
            end else begin
                num_sh <= {num_sh[NUM_W-2:0], 1'b0};
                rem    <= take ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
                quo    <= {quo[NUM_W-2:0], take};
                cnt    <= cnt + 1'b1;
                if (cnt == CNT_W'(NUM_W - 1)) begin
                    busy   <= 1'b0;
                    done_o <= 1'b1;
                    quo_o  <= {quo[NUM_W-2:0], take};
                    tag_o  <= tag_q;
                end
            end
        end
    end
endmodule

// File: rtl/fsw_sched.sv
// Switching frequency scheduler top: maps the load indicator to a scaled
// frequency, inverts it with the background divider, keeps the newest
// result pending, and loads it onto the outputs only on the cycle-start
// strobe. Assumes the strobe spacing is the switching period itself.
module fsw_sched
    import fsw_pkg::*;
#(
    parameter int CLK_HZ  = DEF_CLK_HZ,
    parameter int F_NOM   = DEF_F_NOM,
    parameter int F_MIN   = DEF_F_MIN,
    parameter int KNEE_HI = DEF_KNEE_HI,
    parameter int KNEE_LO = DEF_KNEE_LO,
    parameter int ERR_W   = DEF_ERR_W,
    parameter int PER_W   = DEF_PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_mv_i,
    input  logic             cycle_start_i,
    output logic [PER_W-1:0] period_o,
    output logic             deep_idle_o
);
    localparam int     SPAN    = KNEE_HI - KNEE_LO;
    localparam longint NUM_V   = longint'(CLK_HZ) * longint'(SPAN);
    localparam int     NUM_W   = $clog2(NUM_V + 1);
    localparam longint DEN_MAX = longint'(F_NOM) * longint'(SPAN);
    localparam int     DEN_W   = $clog2(DEN_MAX + 1);
    localparam int     PER_NOM = CLK_HZ / F_NOM;

    logic [DEN_W-1:0] den;
    region_e          region;
    logic             div_done;
    logic [NUM_W-1:0] div_quo;
    region_e          div_tag;
    logic [PER_W-1:0] pend_per;
    logic             pend_idle;

    fsw_region_map #(
        .ERR_W(ERR_W), .KNEE_HI(KNEE_HI), .KNEE_LO(KNEE_LO),
        .F_NOM(F_NOM), .F_MIN(F_MIN), .DEN_W(DEN_W)
    ) u_map (
        .err_i(err_mv_i), .den_o(den), .region_o(region)
    );

    fsw_recip_div #(
        .NUM_W(NUM_W), .DEN_W(DEN_W), .NUM_V(NUM_V)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .den_i(den), .tag_i(region),
        .done_o(div_done), .quo_o(div_quo), .tag_o(div_tag)
    );

    // Keep the newest finished period and idle flag ready for the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_per  <= PER_W'(PER_NOM);
            pend_idle <= 1'b0;
        end else if (div_done) begin
            pend_per  <= div_quo[PER_W-1:0];
            pend_idle <= (div_tag == REG_FLOOR);
        end
    end

    // Move the pending values to the outputs at a switching-cycle boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_o    <= PER_W'(PER_NOM);
            deep_idle_o <= 1'b0;
        end else if (cycle_start_i) begin
            period_o    <= pend_per;
            deep_idle_o <= pend_idle;
        end
    end
endmodule

// File: rtl/fsw_sched_checker.sv
// Checker for the scheduler outputs, bound onto every fsw_sched instance.
module fsw_sched_checker #(
    parameter int PER_W     = 20,
    parameter int PER_NOM   = 238,
    parameter int PER_FLOOR = 18181
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cycle_start_i,
    input logic [PER_W-1:0] period_o,
    input logic             deep_idle_o
);
    // R1: reset loads the nominal period and clears the idle flag
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (period_o == PER_W'(PER_NOM) && !deep_idle_o));

    // R4: idle flag only ever accompanies the floor period
    assert_idle_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        deep_idle_o |-> (period_o == PER_W'(PER_FLOOR)));

    // R6: outputs hold between cycle-start strobes
    assert_hold_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start_i |=> $stable(period_o));
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start_i |=> $stable(deep_idle_o));

    // R8: period stays inside the nominal-to-floor range
    assert_period_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_o >= PER_W'(PER_NOM)) && (period_o <= PER_W'(PER_FLOOR)));
endmodule

bind fsw_sched fsw_sched_checker #(
    .PER_W(PER_W), .PER_NOM(CLK_HZ / F_NOM), .PER_FLOOR(CLK_HZ / F_MIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cycle_start_i(cycle_start_i),
    .period_o(period_o), .deep_idle_o(deep_idle_o)
);

// File: tb/fsw_sched_test.sv
module fsw_sched_test;
    localparam int CLK_P = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] err_mv = '0;
    logic        cyc = 1'b0;
    logic [19:0] period;
    logic        idle;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    fsw_sched uut (
        .clk(clk), .rst_n(rst_n), .err_mv_i(err_mv), .cycle_start_i(cyc),
        .period_o(period), .deep_idle_o(idle)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int exp_period(int e);
        longint x;
        if (e >= 2800) x = 2000;
        else if (e <= 800) x = 0;
        else x = longint'(e - 800);
        return int'(64'd20_000_000_000 / (64'd1_100_000 + x * 64'd41450));
    endfunction

    function automatic bit exp_idle(int e);
        return (e <= 800);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold the error value long enough (R7), then pulse one strobe and check
    task automatic apply(int e, string req);
        @(negedge clk) err_mv = 12'(e);
        repeat (90) @(negedge clk);
        cyc = 1'b1;
        @(negedge clk) cyc = 1'b0;
        check({req, " period"}, int'(period), exp_period(e));
        check({req, " idle"},   int'(idle),   int'(exp_idle(e)));
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int p0, i0;
        void'($urandom(32'h1d1e5eed));
        err_mv = 12'd1800;
        repeat (5) @(negedge clk);
        check("R1 reset period", int'(period), 238);
        check("R1 reset idle", int'(idle), 0);
        @(negedge clk) rst_n = 1'b1;

        // R6: no strobe yet, outputs stay at reset values though divider runs
        repeat (100) @(negedge clk);
        check("R6 hold after reset", int'(period), 238);

        apply(2800, "R2 upper knee");
        apply(4095, "R2 top code");
        apply(2799, "R3 just below upper knee");
        apply(1800, "R3 mid ramp");
        apply(801,  "R5 just above lower knee");
        check("R5 period value", int'(period), 17521);
        apply(800,  "R4 lower knee");
        apply(0,    "R4 zero code");

        // R6: change error with no strobe, outputs must not move
        p0 = int'(period);
        i0 = int'(idle);
        @(negedge clk) err_mv = 12'd3000;
        repeat (120) @(negedge clk);
        check("R6 period held", int'(period), p0);
        check("R6 idle held", int'(idle), i0);

        // R3/R7: random error values across the whole code range
        for (int k = 0; k < 40; k++) begin
            int e;
            e = int'($urandom_range(4095, 0));
            if (k % 3 == 0) e = 800 + int'($urandom_range(2000, 0));
            apply(e, "R3 R7 random");
        end

        // R1: reset mid-operation restores nominal state
        apply(100, "R4 before reset");
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset period", int'(period), 238);
        check("R1 re-reset idle", int'(idle), 0);
        @(negedge clk) rst_n = 1'b1;
        apply(1200, "R3 after reset");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule